// File: doc/BRIEF.md
# Compare Match Interval Timer

This block is a single-channel interval timer. A 16-bit counter counts up on a count enable that comes from a prescaler running on the peripheral clock. The prescaler offers four division ratios, chosen by a 2-bit field. When the counter equals a programmable compare value on a count tick, the counter wraps to zero and a sticky match flag is set. The counter then resumes from zero, so the interval is (compare + 1) count ticks.

Software controls the timer through a small register port with four word addresses:

- **Control/status (address 0):** rate select in bits [1:0], interrupt enable in bit 4, match flag in bit 7.
- **Run (address 1):** start bit in bit 0.
- **Counter (address 2).**
- **Compare (address 3).**

The interrupt output is a level. It is high while the flag and the enable are both 1.

Everything runs in the single peripheral clock domain; there is no derived clock. While the run bit is 0, the prescaler is held at zero. Counting therefore always starts a whole division period after the run bit is set.

Top module: `ivl_timer`

## Requirements
- R1: After reset the counter reads 0, the compare register reads 0xFFFF, and the run register, the control/status register and `irq` all read 0.
- R2: Rate select values 0, 1, 2 and 3 (control bits [1:0]) give one count tick every 8, 32, 128 and 512 clock cycles respectively. With run set at clock edge E, the ticks occur at edges E+N, E+2N, and so on.
- R3: The counter advances only while run (address 1, bit 0) is 1. Writing run to 0 holds the counter at its present value.
- R4: On a tick where the counter equals the compare register, the counter becomes 0 instead of incrementing. After t ticks from zero, the counter therefore reads t mod (compare+1). With compare 0, the counter stays at 0.
- R5: A compare match sets the flag (control bit 7) to 1, and the flag stays 1 until it is cleared by software.
- R6: The flag clears only when a control write with bit 7 equal to 0 follows a read strobe of the control register taken while the flag was 1. A control write without such a read leaves the flag at 1. A clearing write that lands on the same edge as a new match leaves the flag at 1.
- R7: `irq` is 1 exactly when the flag and the interrupt enable (control bit 4) are both 1.
- R8: A counter write (address 2) loads `wdata` and takes priority over an increment on the same edge.
- R9: The compare register (address 3) and the control fields read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms the flag clear) |
| addr | input | 2 | Register address: 0 control/status, 1 run, 2 counter, 3 compare |
| wdata | input | CNT_W (16) | Write data |
| rdata | output | CNT_W (16) | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the timer with its default parameters: a 16-bit counter, a base division of 8 and a step of four between ratios. With these values even the slowest ratio of 512 produces several ticks, and a wrap, in under two thousand cycles. That keeps every rate select, a compare of zero, and wraps at small compare values within one short run. Edge-exact directed tests then place a counter write and a flag-clearing write on the very edge of a tick or a match, to check the priority rules.

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter int CNT_W         = 16,
  parameter int DIV_BASE_LOG2 = 3,
  parameter int DIV_STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);
  localparam int PRE_W = DIV_BASE_LOG2 + 3 * DIV_STEP_LOG2;

  logic [PRE_W-1:0] pre, pre_mask;
  logic [CNT_W-1:0] cnt, cmp;
  logic [1:0]       sel;
  logic             run, ie, flag, armed;
  logic             tick, match;
  logic             wr_ctrl, wr_run, wr_cnt, wr_cmp;

  assign wr_ctrl = wr_en && addr == 2'd0;
  assign wr_run  = wr_en && addr == 2'd1;
  assign wr_cnt  = wr_en && addr == 2'd2;
  assign wr_cmp  = wr_en && addr == 2'd3;

  always_comb pre_mask = (PRE_W'(1) << (DIV_BASE_LOG2 + int'(sel) * DIV_STEP_LOG2)) - PRE_W'(1);
  assign tick  = run && ((pre & pre_mask) == pre_mask);
  assign match = tick && cnt == cmp;
  assign irq   = flag & ie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= run ? pre + PRE_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cnt <= '0;
    else if (wr_cnt) cnt <= wdata;
    else if (match)  cnt <= '0;
    else if (tick)   cnt <= cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp <= '1; sel <= '0; ie <= 1'b0; run <= 1'b0;
    end else begin
      if (wr_cmp)  cmp <= wdata;
      if (wr_run)  run <= wdata[0];
      if (wr_ctrl) begin sel <= wdata[1:0]; ie <= wdata[4]; end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag <= 1'b0; armed <= 1'b0;
    end else begin
      if (match)                                 flag <= 1'b1;
      else if (wr_ctrl && armed && !wdata[7])    flag <= 1'b0;
      if (wr_ctrl)                               armed <= 1'b0;
      else if (rd_en && addr == 2'd0 && flag)    armed <= 1'b1;
    end

  always_comb
    case (addr)
      2'd0:    rdata = CNT_W'({flag, 2'b00, ie, 2'b00, sel});
      2'd1:    rdata = CNT_W'(run);
      2'd2:    rdata = cnt;
      default: rdata = cmp;
    endcase

  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt));
  a_r4_wrap_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !wr_cnt) |=> cnt == '0);
  a_r5_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  a_r6_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed) |=> flag);
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(wdata));
endmodule

// File: tb/sim_ivl_timer.sv
module sim_ivl_timer;
  localparam int CLK_PERIOD = 10;
  // {sel[51:50], ie[49], cmp[48:33], wait_cycles[32:17], exp_cnt[16:1], exp_flag[0]}
  localparam logic [51:0] VEC [0:8] = '{
    {2'd0, 1'b1, 16'd100, 16'd80,   16'd10, 1'b0},
    {2'd0, 1'b1, 16'd3,   16'd40,   16'd1,  1'b1},
    {2'd1, 1'b0, 16'd100, 16'd100,  16'd3,  1'b0},
    {2'd1, 1'b0, 16'd1,   16'd96,   16'd1,  1'b1},
    {2'd2, 1'b0, 16'd10,  16'd127,  16'd0,  1'b0},
    {2'd2, 1'b0, 16'd10,  16'd640,  16'd5,  1'b0},
    {2'd3, 1'b1, 16'd2,   16'd1536, 16'd0,  1'b1},
    {2'd3, 1'b0, 16'd50,  16'd1535, 16'd2,  1'b0},
    {2'd0, 1'b0, 16'd0,   16'd24,   16'd0,  1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, irq;
  logic [1:0] addr = 2'd0;
  logic [15:0] wdata = '0, rdata;
  int checks = 0, fails = 0;

  ivl_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_strobe(input logic [1:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
    end
  endtask

  task automatic clear_flag_and_stop(input logic [15:0] ctrl);
    wr(2'd1, 16'd0);
    rd_strobe(2'd0);
    wr(2'd0, ctrl);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] d, held;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(2'd2, d); check("R1 counter", d, 16'h0000);
    peek(2'd3, d); check("R1 compare", d, 16'hFFFF);
    peek(2'd1, d); check("R1 run", d, 16'h0000);
    peek(2'd0, d); check("R1 control", d, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);

    foreach (VEC[i]) begin
      logic [51:0] v;
      v = VEC[i];
      clear_flag_and_stop({11'd0, v[49], 2'b00, v[51:50]});
      wr(2'd2, 16'd0);
      wr(2'd3, v[48:33]);
      peek(2'd3, d); check("R9 compare readback", d, v[48:33]);
      peek(2'd0, d); check("R9 control readback", d, {11'd0, v[49], 2'b00, v[51:50]});
      wr(2'd1, 16'd1);
      repeat (int'(v[32:17])) @(negedge clk);
      peek(2'd2, d); check("R2/R4 counter after wait", d, v[16:1]);
      peek(2'd0, d); check("R5 flag after wait", {15'd0, d[7]}, {15'd0, v[0]});
      check("R7 irq level", {15'd0, irq}, {15'd0, v[0] & v[49]});
    end

    // R5/R6: flag set by last vector; write without read leaves flag
    wr(2'd1, 16'd0);
    wr(2'd0, 16'd0);
    peek(2'd0, d); check("R6 write without read keeps flag", {15'd0, d[7]}, 16'd1);
    rd_strobe(2'd0);
    wr(2'd0, 16'd0);
    peek(2'd0, d); check("R6 read then write clears flag", {15'd0, d[7]}, 16'd0);

    // R3: stop holds counter
    wr(2'd3, 16'd1000);
    wr(2'd2, 16'd0);
    wr(2'd1, 16'd1);
    repeat (40) @(negedge clk);
    wr(2'd1, 16'd0);
    peek(2'd2, held);
    repeat (100) @(negedge clk);
    peek(2'd2, d); check("R3 stopped counter holds", d, held);
    check("R3 counter advanced before stop", held, 16'd5);

    // R8: counter write on a tick edge (E0 = run-set edge, tick at E0+8)
    wr(2'd2, 16'd0);
    wr(2'd1, 16'd1);
    repeat (7) @(negedge clk);
    wr(2'd2, 16'd500);
    peek(2'd2, d); check("R8 write beats increment", d, 16'd500);
    repeat (8) @(negedge clk);
    peek(2'd2, d); check("R8 counting resumes from written value", d, 16'd501);

    // R6: clearing write on a match edge keeps the flag; R7 irq with enable
    clear_flag_and_stop(16'd0);
    wr(2'd2, 16'd0);
    wr(2'd3, 16'd0);
    wr(2'd1, 16'd1);
    repeat (9) @(negedge clk);
    peek(2'd0, d); check("R4/R5 compare 0 sets flag on first tick", {15'd0, d[7]}, 16'd1);
    rd_strobe(2'd0);
    repeat (5) @(negedge clk);
    wr(2'd0, 16'h0010);
    peek(2'd0, d); check("R6 match on clearing edge keeps flag", {15'd0, d[7]}, 16'd1);
    check("R7 irq with flag and enable", {15'd0, irq}, 16'd1);
    peek(2'd2, d); check("R4 compare 0 holds counter at 0", d, 16'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule